// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Controller

This block keeps the event status word and the interrupt-enable word of an SD/MMC host controller. Single-cycle event pulses arrive from the command engine, the data engine, the card buffer and card detection. Each pulse sets a sticky bit that stays set until software writes a one to that bit position. The status word also carries three live level bits that are passed straight through, and a two-bit code from the card's write-CRC token.

Software reads both words over a small register bus and clears events by writing back the value it read. A single interrupt request is raised whenever an enabled completion or card-detect event is latched. A decoded error view gives the masked error field and a timeout/CRC classification, so a handler can pick the failure class without decoding bits.

Top module: `sdh_stat_irq`

## Requirements
- R1: After synchronous reset the sticky status bits, the write-CRC code and the enable word are all zero, and `irq` is low.
- R2: A one-cycle pulse on an event input sets its status bit from the next clock edge on. The bit positions are: card inserted 31, card removed 30, command response end 13, write done 12, read/transfer done 11, response CRC error 5, read CRC error 3, write CRC error 2, response timeout 1, read timeout 0.
- R3: A bus write to the status address (index 0) clears each sticky bit whose data bit is one. Sticky bits written with zero keep their value.
- R4: If an event pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R5: Status bits 8 (card clock running), 7 (buffer ready to read) and 6 (buffer ready to write) follow their level inputs in the same cycle. They are never latched and writes do not affect them.
- R6: Status bits [10:9] hold the code sampled on `wcrc_code` when the write-CRC error pulse arrives. Clearing bit 2 also returns the code to zero. Writes to bits [10:9] have no effect.
- R7: `err_mask` equals status bits [5:0] ANDed with 0x2F.
- R8: `err_timeout` is set when a response timeout or a read timeout is latched, or when a write CRC error is latched with code 2. `err_crc` is set when a response CRC error or a read CRC error is latched, or when a write CRC error is latched with any code other than 2.
- R9: A write to the enable address (index 1) stores only bits 0 (read done), 1 (write done), 2 (command end), 14 (removal) and 15 (insertion). All other bits read back as zero. Writing zero disables every source.
- R10: `irq` is the OR of the five enabled pairs: read done (bit 11) with enable bit 0, write done (12) with 1, command end (13) with 2, removal (30) with 14, and insertion (31) with 15.
- R11: Reads from any address other than 0 and 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | ADDR_W | Word index: 0 status, 1 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_cmd_end | input | 1 | Command response finished |
| ev_wr_done | input | 1 | Write operation finished |
| ev_rd_done | input | 1 | Read or data transfer finished |
| ev_rsp_crc | input | 1 | Response CRC mismatch |
| ev_rd_crc | input | 1 | Read data CRC mismatch |
| ev_wr_crc | input | 1 | Write CRC token error |
| wcrc_code | input | 2 | Write CRC token code, sampled with `ev_wr_crc` |
| ev_rsp_to | input | 1 | Response timeout |
| ev_rd_to | input | 1 | Read data timeout |
| ev_card_in | input | 1 | Card inserted |
| ev_card_out | input | 1 | Card removed |
| lv_rd_rdy | input | 1 | Buffer holds data to read (level) |
| lv_wr_rdy | input | 1 | Buffer can accept data (level) |
| lv_clk_run | input | 1 | Card clock running (level) |
| irq | output | 1 | Interrupt request |
| err_mask | output | 6 | Status [5:0] AND 0x2F |
| err_timeout | output | 1 | Timeout class error latched |
| err_crc | output | 1 | CRC class error latched |

## Verification
Sticky bits, the write-CRC code and the enable word change only at the clock edge that samples the pulse or write. `bus_rdata`, `irq` and the error outputs are combinational from that state, so each result is due at the first falling edge after that rising edge. Live bits appear in the same cycle their inputs change. The driver applies each stimulus at a falling edge and removes it at the next falling edge, which lies after exactly one rising edge. Only then does it queue the expected value, and the monitor compares shortly after that falling edge, well away from any rising edge. The same-cycle collision of an event with a clearing write, and both write-CRC code classes, are driven as explicit cases.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;

    localparam int DATA_W   = 32;
    localparam int N_STICKY = 10;
    localparam int N_IEN    = 5;
    localparam int IRQ_BASE = 5;

    localparam int B_DTO     = 0;
    localparam int B_RTO     = 1;
    localparam int B_DCRC_WR = 2;
    localparam int B_DCRC_RD = 3;
    localparam int B_RCRC    = 5;
    localparam int B_WRDY    = 6;
    localparam int B_RRDY    = 7;
    localparam int B_CLKRUN  = 8;
    localparam int B_WCODE   = 9;
    localparam int B_RDD     = 11;
    localparam int B_WRD     = 12;
    localparam int B_CMD     = 13;
    localparam int B_REM     = 30;
    localparam int B_INS     = 31;

    localparam logic [5:0] ERR_SEL      = 6'h2F;
    localparam logic [1:0] WCODE_NOTOKEN = 2'd2;

    // Packed event bundle; bit index equals sticky index.
    typedef struct packed {
        logic ins;
        logic rem;
        logic cmd_end;
        logic wr_done;
        logic rd_done;
        logic rsp_crc;
        logic rd_crc;
        logic wr_crc;
        logic rsp_to;
        logic rd_to;
    } evt_t;

    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return B_DTO;
            1:       return B_RTO;
            2:       return B_DCRC_WR;
            3:       return B_DCRC_RD;
            4:       return B_RCRC;
            5:       return B_RDD;
            6:       return B_WRD;
            7:       return B_CMD;
            8:       return B_REM;
            default: return B_INS;
        endcase
    endfunction

    // Enable index k pairs with sticky index IRQ_BASE + k.
    function automatic int ien_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 14;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sdh_wcode_reg.sv
module sdh_wcode_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_i,
    input  logic [1:0] code_i,
    input  logic       clr_i,
    output logic [1:0] code_o
);
    always_ff @(posedge clk) begin
        if (rst)
            code_o <= 2'd0;
        else if (cap_i)
            code_o <= code_i;
        else if (clr_i)
            code_o <= 2'd0;
    end
endmodule

// File: rtl/sdh_ien_reg.sv
module sdh_ien_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/sdh_irq_merge.sv
module sdh_irq_merge
    import sdh_stat_pkg::*;
#(
    parameter int N = 5
) (
    input  logic [5:0]   stat_lo_i,
    input  logic [1:0]   code_i,
    input  logic [N-1:0] done_i,
    input  logic [N-1:0] ien_i,
    output logic         irq_o,
    output logic [5:0]   err_mask_o,
    output logic         err_to_o,
    output logic         err_crc_o
);
    logic no_token;

    always_comb begin
        no_token   = (code_i == WCODE_NOTOKEN);
        irq_o      = |(done_i & ien_i);
        err_mask_o = stat_lo_i & ERR_SEL;
        err_to_o   = stat_lo_i[B_DTO] | stat_lo_i[B_RTO]
                   | (stat_lo_i[B_DCRC_WR] & no_token);
        err_crc_o  = stat_lo_i[B_RCRC] | stat_lo_i[B_DCRC_RD]
                   | (stat_lo_i[B_DCRC_WR] & ~no_token);
    end
endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
    import sdh_stat_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int ADDR_STAT = 0,
    parameter int ADDR_IEN  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_cmd_end,
    input  logic              ev_wr_done,
    input  logic              ev_rd_done,
    input  logic              ev_rsp_crc,
    input  logic              ev_rd_crc,
    input  logic              ev_wr_crc,
    input  logic [1:0]        wcrc_code,
    input  logic              ev_rsp_to,
    input  logic              ev_rd_to,
    input  logic              ev_card_in,
    input  logic              ev_card_out,
    input  logic              lv_rd_rdy,
    input  logic              lv_wr_rdy,
    input  logic              lv_clk_run,
    output logic              irq,
    output logic [5:0]        err_mask,
    output logic              err_timeout,
    output logic              err_crc
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADDR_IEN);

    evt_t                       evt;
    logic [N_STICKY-1:0]        clr_vec;
    logic [N_STICKY-1:0]        sticky_q;
    logic [N_IEN-1:0]           ien_d;
    logic [N_IEN-1:0]           ien_q;
    logic [1:0]                 code_q;
    logic                       wr_stat;
    logic                       wr_ien;
    logic [DATA_W-1:0]          stat_word;
    logic [DATA_W-1:0]          ien_word;
    logic                       wdata_unused;

    assign evt = '{ins: ev_card_in, rem: ev_card_out, cmd_end: ev_cmd_end,
                   wr_done: ev_wr_done, rd_done: ev_rd_done,
                   rsp_crc: ev_rsp_crc, rd_crc: ev_rd_crc, wr_crc: ev_wr_crc,
                   rsp_to: ev_rsp_to, rd_to: ev_rd_to};

    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_ien  = bus_wr && (bus_addr == A_IEN);
    assign wdata_unused = ^bus_wdata;

    for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
        assign clr_vec[i] = wr_stat & bus_wdata[sticky_pos(i)];
    end

    for (genvar k = 0; k < N_IEN; k++) begin : g_ien
        assign ien_d[k] = bus_wdata[ien_pos(k)];
    end

    sdh_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    sdh_wcode_reg u_wcode (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (ev_wr_crc),
        .code_i (wcrc_code),
        .clr_i  (clr_vec[2]),
        .code_o (code_q)
    );

    sdh_ien_reg #(.N(N_IEN)) u_ien (
        .clk  (clk),
        .rst  (rst),
        .we_i (wr_ien),
        .d_i  (ien_d),
        .q_o  (ien_q)
    );

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < N_STICKY; i++)
            stat_word[sticky_pos(i)] = sticky_q[i];
        stat_word[B_WCODE +: 2] = code_q;
        stat_word[B_CLKRUN]     = lv_clk_run;
        stat_word[B_RRDY]       = lv_rd_rdy;
        stat_word[B_WRDY]       = lv_wr_rdy;
    end

    always_comb begin
        ien_word = '0;
        for (int k = 0; k < N_IEN; k++)
            ien_word[ien_pos(k)] = ien_q[k];
    end

    always_comb begin
        if (bus_addr == A_STAT)
            bus_rdata = stat_word;
        else if (bus_addr == A_IEN)
            bus_rdata = ien_word;
        else
            bus_rdata = '0;
    end

    sdh_irq_merge #(.N(N_IEN)) u_merge (
        .stat_lo_i  (stat_word[5:0]),
        .code_i     (code_q),
        .done_i     (sticky_q[IRQ_BASE +: N_IEN]),
        .ien_i      (ien_q),
        .irq_o      (irq),
        .err_mask_o (err_mask),
        .err_to_o   (err_timeout),
        .err_crc_o  (err_crc)
    );
endmodule

// File: rtl/sdh_stat_irq_chk.sv
module sdh_stat_irq_chk #(
    parameter int ADDR_W    = 2,
    parameter int ADDR_STAT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              ev_cmd_end,
    input logic              ev_card_in,
    input logic              ev_rd_to,
    input logic              lv_rd_rdy,
    input logic              irq,
    input logic              err_timeout,
    input logic [31:0]       stat_word,
    input logic [31:0]       ien_word
);
    logic wr_st;
    logic chk_unused;
    assign wr_st = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
    assign chk_unused = ^{stat_word, bus_wdata, ien_word, bus_rdata};

    p_rst_r1: assert property (@(posedge clk)
        $past(rst) |-> (ien_word == 32'd0 && !irq));

    p_set_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        ev_cmd_end |=> stat_word[13]);

    p_set_ins_r2: assert property (@(posedge clk) disable iff (rst)
        ev_card_in |=> stat_word[31]);

    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_word[12] && !(wr_st && bus_wdata[12])) |=> stat_word[12]);

    p_evwin_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_rd_to && wr_st && bus_wdata[0]) |=> stat_word[0]);

    p_live_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(ADDR_STAT)) |-> (bus_rdata[7] == lv_rd_rdy));

    p_to_src_r8: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (stat_word[0] || stat_word[1] || stat_word[2]));

    p_off_r9: assert property (@(posedge clk) disable iff (rst)
        (ien_word == 32'd0) |-> !irq);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_word[11] || stat_word[12] || stat_word[13]
                 || stat_word[30] || stat_word[31]));
endmodule

bind sdh_stat_irq sdh_stat_irq_chk #(
    .ADDR_W    (ADDR_W),
    .ADDR_STAT (ADDR_STAT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ev_cmd_end  (ev_cmd_end),
    .ev_card_in  (ev_card_in),
    .ev_rd_to    (ev_rd_to),
    .lv_rd_rdy   (lv_rd_rdy),
    .irq         (irq),
    .err_timeout (err_timeout),
    .stat_word   (stat_word),
    .ien_word    (ien_word)
);

// File: tb/sim_sdh_stat_irq.sv
module sim_sdh_stat_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic ev_cmd_end = 0, ev_wr_done = 0, ev_rd_done = 0;
    logic ev_rsp_crc = 0, ev_rd_crc = 0, ev_wr_crc = 0;
    logic [1:0] wcrc_code = 2'd0;
    logic ev_rsp_to = 0, ev_rd_to = 0, ev_card_in = 0, ev_card_out = 0;
    logic lv_rd_rdy = 0, lv_wr_rdy = 0, lv_clk_run = 0;
    logic       irq;
    logic [5:0] err_mask;
    logic       err_timeout;
    logic       err_crc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef enum int {K_RD, K_IRQ, K_EMASK, K_ETO, K_ECRC} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    sdh_stat_irq u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_cmd_end(ev_cmd_end), .ev_wr_done(ev_wr_done), .ev_rd_done(ev_rd_done),
        .ev_rsp_crc(ev_rsp_crc), .ev_rd_crc(ev_rd_crc), .ev_wr_crc(ev_wr_crc),
        .wcrc_code(wcrc_code), .ev_rsp_to(ev_rsp_to), .ev_rd_to(ev_rd_to),
        .ev_card_in(ev_card_in), .ev_card_out(ev_card_out),
        .lv_rd_rdy(lv_rd_rdy), .lv_wr_rdy(lv_wr_rdy), .lv_clk_run(lv_clk_run),
        .irq(irq), .err_mask(err_mask), .err_timeout(err_timeout), .err_crc(err_crc)
    );

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {31'd0, irq};
                    K_EMASK: act = {26'd0, err_mask};
                    K_ETO:   act = {31'd0, err_timeout};
                    default: act = {31'd0, err_crc};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input kind_t k, input logic [1:0] a,
                              input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = k;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        expect_val(K_RD, 2'd0, 32'h0, "R1 status after reset");
        expect_val(K_RD, 2'd1, 32'h0, "R1 enable after reset");
        expect_val(K_IRQ, 2'd0, 32'h0, "R1 irq after reset");

        // R2: command end latched, no enable yet
        @(negedge clk); ev_cmd_end = 1;
        @(negedge clk); ev_cmd_end = 0;
        expect_val(K_RD, 2'd0, 32'h0000_2000, "R2 cmd end bit 13");
        repeat (2) @(negedge clk);
        expect_val(K_RD, 2'd0, 32'h0000_2000, "R2 cmd end sticky");
        expect_val(K_IRQ, 2'd0, 32'h0, "R10 irq masked");

        // R9: only enable bits 0,1,2,14,15 store
        wr(2'd1, 32'hFFFF_FFFF);
        expect_val(K_RD, 2'd1, 32'h0000_C007, "R9 enable readback");
        expect_val(K_IRQ, 2'd0, 32'h1, "R10 irq cmd end enabled");

        // R11: unmapped address
        expect_val(K_RD, 2'd2, 32'h0, "R11 unmapped read");

        // R3: zero write keeps, one write clears
        wr(2'd0, 32'h0000_0000);
        expect_val(K_RD, 2'd0, 32'h0000_2000, "R3 zero write keeps");
        wr(2'd0, 32'h0000_2000);
        expect_val(K_RD, 2'd0, 32'h0, "R3 one write clears");
        expect_val(K_IRQ, 2'd0, 32'h0, "R10 irq drops after clear");

        // R2: several sources at once
        @(negedge clk); ev_card_in = 1; ev_card_out = 1; ev_wr_done = 1; ev_rd_done = 1;
        @(negedge clk); ev_card_in = 0; ev_card_out = 0; ev_wr_done = 0; ev_rd_done = 0;
        expect_val(K_RD, 2'd0, 32'hC000_1800, "R2 card and done bits");
        expect_val(K_IRQ, 2'd0, 32'h1, "R10 irq from done events");

        // R9: zero disables all
        wr(2'd1, 32'h0);
        expect_val(K_IRQ, 2'd0, 32'h0, "R9 zero enable disables irq");
        expect_val(K_RD, 2'd0, 32'hC000_1800, "R9 status unaffected");

        // R10: insertion only
        wr(2'd1, 32'h0000_8000);
        expect_val(K_IRQ, 2'd0, 32'h1, "R10 irq insertion enabled");
        wr(2'd0, 32'h8000_0000);
        expect_val(K_IRQ, 2'd0, 32'h0, "R10 irq after insertion clear");
        expect_val(K_RD, 2'd0, 32'h4000_1800, "R3 partial clear");

        // R4: event wins over same-cycle clear
        @(negedge clk);
        bus_wr = 1; bus_addr = 2'd0; bus_wdata = 32'hFFFF_FFFF; ev_rd_to = 1;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 32'h0; ev_rd_to = 0;
        expect_val(K_RD, 2'd0, 32'h0000_0001, "R4 event beats clear");
        expect_val(K_EMASK, 2'd0, 32'h01, "R7 mask read timeout");
        expect_val(K_ETO, 2'd0, 32'h1, "R8 timeout from read timeout");
        expect_val(K_ECRC, 2'd0, 32'h0, "R8 no crc class");

        // R5: live bits pass through and ignore clears
        @(negedge clk); lv_rd_rdy = 1; lv_wr_rdy = 1; lv_clk_run = 1;
        expect_val(K_RD, 2'd0, 32'h0000_01C1, "R5 live bits shown");
        wr(2'd0, 32'h0000_01C0);
        expect_val(K_RD, 2'd0, 32'h0000_01C1, "R5 live bits ignore clear");
        lv_rd_rdy = 0; lv_wr_rdy = 0; lv_clk_run = 0;
        expect_val(K_RD, 2'd0, 32'h0000_0001, "R5 live bits follow input");

        // R6/R8: write CRC with no-token code 2
        @(negedge clk); ev_wr_crc = 1; wcrc_code = 2'd2;
        @(negedge clk); ev_wr_crc = 0; wcrc_code = 2'd0;
        expect_val(K_RD, 2'd0, 32'h0000_0405, "R6 code 2 captured");
        wr(2'd0, 32'h0000_0001);
        expect_val(K_ETO, 2'd0, 32'h1, "R8 code 2 is timeout");
        expect_val(K_ECRC, 2'd0, 32'h0, "R8 code 2 not crc");
        wr(2'd0, 32'h0000_0600);
        expect_val(K_RD, 2'd0, 32'h0000_0404, "R6 code bits not writable");
        wr(2'd0, 32'h0000_0004);
        expect_val(K_RD, 2'd0, 32'h0, "R6 code cleared with bit 2");
        expect_val(K_ETO, 2'd0, 32'h0, "R8 timeout gone");

        // R6/R8: write CRC with code 1
        @(negedge clk); ev_wr_crc = 1; wcrc_code = 2'd1;
        @(negedge clk); ev_wr_crc = 0; wcrc_code = 2'd0;
        expect_val(K_RD, 2'd0, 32'h0000_0204, "R6 code 1 captured");
        expect_val(K_ECRC, 2'd0, 32'h1, "R8 code 1 is crc");
        expect_val(K_ETO, 2'd0, 32'h0, "R8 code 1 not timeout");
        wr(2'd0, 32'h0000_0004);

        // R7: remaining error sources
        @(negedge clk); ev_rsp_crc = 1; ev_rd_crc = 1; ev_rsp_to = 1;
        @(negedge clk); ev_rsp_crc = 0; ev_rd_crc = 0; ev_rsp_to = 0;
        expect_val(K_RD, 2'd0, 32'h0000_002A, "R2 error bits");
        expect_val(K_EMASK, 2'd0, 32'h2A, "R7 error mask");
        expect_val(K_ECRC, 2'd0, 32'h1, "R8 crc class");
        expect_val(K_ETO, 2'd0, 32'h1, "R8 response timeout");

        done = 1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule